// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker

This block holds a single address reservation for one hardware thread so that a load-linked / store-conditional pair behaves as one indivisible read-modify-write. A load-linked request arms the reservation and records the cache line that was read. Every store seen in the system is compared with that line, whether the local thread or a remote requester issued it. A store that hits the line cancels the reservation. Any other work between the pair leaves it alone.

When a store-conditional arrives, the block decides whether it may go ahead. It succeeds only if the reservation is still armed and the conditional store targets the recorded line. On success the block drives a one-cycle write enable, with address and data, to the word memory behind it. On failure nothing is written and a condition flag reports the failure, so software can retry the pair.

Addresses are compared per cache line, and the number of offset bits is a parameter. Store observation ports are a parameterized vector. Port 0 carries the local thread's stores and the higher ports carry remote stores. All results are registered and appear one clock after the request.

Top module: `linked_resv_unit`

## Requirements
- R1: A load-linked request (`ll_req_i`) arms the reservation with the line `ll_addr_i[AW-1:OFF_W]`. A new load-linked replaces any earlier reservation, and the old line no longer matches.
- R2: An observed store whose line equals the reserved line clears the reservation. Stores to other lines have no effect.
- R3: Stores on the remote ports (index 1 and up of `st_seen_i`, with the address of port k in `st_addr_i[k*AW +: AW]`) clear the reservation exactly as the local port 0 does.
- R4: A store-conditional succeeds when the reservation is armed and the line of `sc_addr_i` equals the reserved line. One cycle after the request, `sc_done_o`=1, `sc_ok_o`=1 and `mem_we_o`=1, with `mem_addr_o`/`mem_data_o` equal to the request's address and data.
- R5: A failed store-conditional gives `sc_done_o`=1, `sc_ok_o`=0 and `mem_we_o`=0 one cycle later. It sets `cc_fail_o`, which holds its value until the next store-conditional result replaces it.
- R6: Every store-conditional, successful or not, disarms the reservation. A second store-conditional without a new load-linked fails.
- R7: Reset disarms the reservation and clears `sc_done_o`, `sc_ok_o`, `mem_we_o` and `cc_fail_o`. A store-conditional issued straight after reset fails.
- R8: If a store to the reserved line and a store-conditional arrive in the same cycle, the store wins and the store-conditional fails.
- R9: If a load-linked and a store-conditional arrive in the same cycle, the store-conditional is judged against the previous reservation and the load-linked then arms the new one. A load-linked that coincides with a store to the same line still arms.
- R10: Addresses that differ only in the low `OFF_W` bits count as the same line, both for store-conditional success and for store kills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ll_req_i | input | 1 | Load-linked request strobe |
| ll_addr_i | input | AW | Load-linked address |
| sc_req_i | input | 1 | Store-conditional request strobe |
| sc_addr_i | input | AW | Store-conditional address |
| sc_data_i | input | DW | Store-conditional write data |
| st_seen_i | input | N_OBS | Valid strobe per store observation port (0 local, others remote) |
| st_addr_i | input | N_OBS*AW | Observed store addresses, port k at [k*AW +: AW] |
| sc_done_o | output | 1 | Store-conditional result valid (one-cycle pulse) |
| sc_ok_o | output | 1 | Store-conditional succeeded |
| cc_fail_o | output | 1 | Condition flag: last store-conditional failed |
| mem_we_o | output | 1 | Write enable to the word memory |
| mem_addr_o | output | AW | Write address |
| mem_data_o | output | DW | Write data |

## Verification
The bench sweeps every pair of load-linked and store-conditional addresses in a small configuration. A comparator that looks at the full address instead of the line would fail the pairs that differ only in offset bits. It also kills reservations from each store port in turn, across every line. A design that ignored the remote ports, or killed on any store at all, would then give the wrong success pattern. Same-cycle collisions are driven on purpose: store against conditional, load-linked against conditional, and load-linked against store. A wrong priority in any of them shows up as a success that should have failed, or the reverse. It also checks that a repeated conditional fails and that the failure flag holds between results, which catches a reservation left armed after use or a flag that only pulses.

// File: rtl/resv_pkg.sv
package resv_pkg;

    // Outcome of a store-conditional as seen by the response stage
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_PASS = 2'd1,
        SC_FAIL = 2'd2
    } sc_outcome_e;

    function automatic sc_outcome_e judge_sc(
        input logic req,
        input logic armed,
        input logic line_hit,
        input logic killed
    );
        if (!req)
            return SC_IDLE;
        else if (armed && line_hit && !killed)
            return SC_PASS;
        else
            return SC_FAIL;
    endfunction

endpackage

// File: rtl/line_cmp.sv
module line_cmp #(
    parameter int AW    = 32,
    parameter int OFF_W = 6
) (
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-OFF_W-1:0] line_i,
    output logic          hit_o
);
    localparam int LW = AW - OFF_W;

    logic [LW-1:0] addr_line;

    always_comb begin
        addr_line = addr_i[AW-1:OFF_W];
        hit_o     = en_i && (addr_line == line_i);
    end
endmodule

// File: rtl/kill_detect.sv
module kill_detect #(
    parameter int AW    = 32,
    parameter int OFF_W = 6,
    parameter int N_OBS = 4
) (
    input  logic                  armed_i,
    input  logic [AW-OFF_W-1:0]   line_i,
    input  logic [N_OBS-1:0]      st_seen_i,
    input  logic [N_OBS*AW-1:0]   st_addr_i,
    output logic [N_OBS-1:0]      port_hit_o,
    output logic                  kill_o
);
    for (genvar k = 0; k < N_OBS; k++) begin : g_port
        line_cmp #(
            .AW    (AW),
            .OFF_W (OFF_W)
        ) cmp_i (
            .en_i   (st_seen_i[k]),
            .addr_i (st_addr_i[k*AW +: AW]),
            .line_i (line_i),
            .hit_o  (port_hit_o[k])
        );
    end

    always_comb begin
        kill_o = armed_i && (|port_hit_o);
    end
endmodule

// File: rtl/linked_resv_unit.sv
module linked_resv_unit
    import resv_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFF_W = 6,
    parameter int N_OBS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ll_req_i,
    input  logic [AW-1:0]       ll_addr_i,
    input  logic                sc_req_i,
    input  logic [AW-1:0]       sc_addr_i,
    input  logic [DW-1:0]       sc_data_i,
    input  logic [N_OBS-1:0]    st_seen_i,
    input  logic [N_OBS*AW-1:0] st_addr_i,
    output logic                sc_done_o,
    output logic                sc_ok_o,
    output logic                cc_fail_o,
    output logic                mem_we_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [DW-1:0]       mem_data_o
);
    localparam int LW = AW - OFF_W;

    typedef struct packed {
        logic          armed;
        logic [LW-1:0] line;
        logic          done;
        logic          ok;
        logic          cc_fail;
        logic          we;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } resv_state_t;

    resv_state_t st_d, st_q;

    logic [N_OBS-1:0] port_hit;
    logic             kill_hit;
    logic             sc_line_hit;
    sc_outcome_e      outcome;

    kill_detect #(
        .AW    (AW),
        .OFF_W (OFF_W),
        .N_OBS (N_OBS)
    ) kill_i (
        .armed_i    (st_q.armed),
        .line_i     (st_q.line),
        .st_seen_i  (st_seen_i),
        .st_addr_i  (st_addr_i),
        .port_hit_o (port_hit),
        .kill_o     (kill_hit)
    );

    line_cmp #(
        .AW    (AW),
        .OFF_W (OFF_W)
    ) sc_cmp_i (
        .en_i   (sc_req_i),
        .addr_i (sc_addr_i),
        .line_i (st_q.line),
        .hit_o  (sc_line_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        outcome   = judge_sc(sc_req_i, st_q.armed, sc_line_hit, kill_hit);

        if (outcome != SC_IDLE) begin
            st_d.done    = 1'b1;
            st_d.ok      = (outcome == SC_PASS);
            st_d.cc_fail = (outcome == SC_FAIL);
            st_d.we      = (outcome == SC_PASS);
            st_d.waddr   = sc_addr_i;
            st_d.wdata   = sc_data_i;
        end

        // A new link always wins; otherwise any conditional or hit disarms
        if (ll_req_i) begin
            st_d.armed = 1'b1;
            st_d.line  = ll_addr_i[AW-1:OFF_W];
        end else if (sc_req_i || kill_hit) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sc_done_o  = st_q.done;
    assign sc_ok_o    = st_q.ok;
    assign cc_fail_o  = st_q.cc_fail;
    assign mem_we_o   = st_q.we;
    assign mem_addr_o = st_q.waddr;
    assign mem_data_o = st_q.wdata;

    // R1: a link arms with the requested line
    p_ll_arms_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ll_req_i |=> (st_q.armed && st_q.line == $past(ll_addr_i[AW-1:OFF_W])));

    // R2/R3: a hit from any port without a new link disarms
    p_kill_disarms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|port_hit) && st_q.armed && !ll_req_i) |=> !st_q.armed);

    // R4: a write only follows an armed reservation and a request
    p_we_needs_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> ($past(st_q.armed) && $past(sc_req_i)));

    // R5: a failed result raises the condition flag
    p_fail_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_done_o && !sc_ok_o) |-> (cc_fail_o && !mem_we_o));

    // R6: a conditional without a link leaves nothing armed
    p_sc_disarms_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_req_i && !ll_req_i) |=> !st_q.armed);

    // R8: a colliding store beats the conditional
    p_store_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_req_i && kill_hit) |=> (sc_done_o && !mem_we_o));

    // R5: the flag only moves with a result
    p_flag_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sc_done_o |-> $stable(cc_fail_o));
endmodule

// File: tb/linked_resv_unit_tb_top.sv
module linked_resv_unit_tb_top;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int OFF_W = 2;
    localparam int N_OBS = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ll_req = 1'b0;
    logic [AW-1:0]       ll_addr = '0;
    logic                sc_req = 1'b0;
    logic [AW-1:0]       sc_addr = '0;
    logic [DW-1:0]       sc_data = '0;
    logic [N_OBS-1:0]    st_seen = '0;
    logic [N_OBS*AW-1:0] st_addr = '0;
    logic                sc_done, sc_ok, cc_fail, mem_we;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    linked_resv_unit #(
        .AW(AW), .DW(DW), .OFF_W(OFF_W), .N_OBS(N_OBS)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ll_req_i(ll_req), .ll_addr_i(ll_addr),
        .sc_req_i(sc_req), .sc_addr_i(sc_addr), .sc_data_i(sc_data),
        .st_seen_i(st_seen), .st_addr_i(st_addr),
        .sc_done_o(sc_done), .sc_ok_o(sc_ok), .cc_fail_o(cc_fail),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, return at the next falling edge
    task automatic cyc(input bit do_ll, input int la, input bit do_sc, input int sa,
                       input int port, input int ta);
        @(negedge clk);
        ll_req  = do_ll;
        ll_addr = AW'(la);
        sc_req  = do_sc;
        sc_addr = AW'(sa);
        sc_data = DW'((sa * 7 + 3) & 8'hFF);
        st_seen = '0;
        st_addr = '0;
        if (port >= 0) begin
            st_seen[port] = 1'b1;
            st_addr[port*AW +: AW] = AW'(ta);
        end
        @(negedge clk);
        ll_req  = 1'b0;
        sc_req  = 1'b0;
        st_seen = '0;
    endtask

    // Outputs reflect the conditional driven in the preceding cyc call
    task automatic expect_sc(input string req, input bit ok, input int sa);
        chk({req, " done"}, int'(sc_done), 1);
        chk({req, " ok"}, int'(sc_ok), int'(ok));
        chk({req, " we"}, int'(mem_we), int'(ok));
        chk({req, " cc"}, int'(cc_fail), int'(!ok));
        if (ok) begin
            chk({req, " addr"}, int'(mem_addr), sa);
            chk({req, " data"}, int'(mem_data), (sa * 7 + 3) & 8'hFF);
        end
    endtask

    function automatic int ln(input int a);
        return a >> OFF_W;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 done", int'(sc_done), 0);
        chk("R7 we", int'(mem_we), 0);
        chk("R7 cc", int'(cc_fail), 0);
        rst_n = 1'b1;
        cyc(0, 0, 1, 0, -1, 0);
        expect_sc("R7 sc after reset", 0, 0);

        // R4/R10: every link address against every conditional address
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                bit ok;
                ok = (ln(a) == ln(b));
                cyc(1, a, 0, 0, -1, 0);
                cyc(0, 0, 1, b, -1, 0);
                expect_sc("R4/R10 pair", ok, b);
                if (ok && b[0]) begin
                    cyc(0, 0, 1, b, -1, 0);
                    expect_sc("R6 repeat", 0, b);
                end
            end
        end

        // R2/R3/R10: a store on each port to each line, in between
        for (int a = 0; a < 64; a += 3) begin
            for (int p = 0; p < N_OBS; p++) begin
                for (int l = 0; l < 16; l++) begin
                    int t;
                    t = (l << OFF_W) | ((a + p + 1) & 3);
                    cyc(1, a, 0, 0, -1, 0);
                    cyc(0, 0, 0, 0, p, t);
                    cyc(0, 0, 1, a, -1, 0);
                    expect_sc(p == 0 ? "R2 local kill" : "R3 remote kill",
                              ln(t) != ln(a), a);
                end
            end
        end

        // R1: a second link replaces the first
        cyc(1, 8, 0, 0, -1, 0);
        cyc(1, 40, 0, 0, -1, 0);
        cyc(0, 0, 1, 9, -1, 0);
        expect_sc("R1 old line", 0, 9);
        cyc(1, 8, 0, 0, -1, 0);
        cyc(1, 40, 0, 0, -1, 0);
        cyc(0, 0, 1, 41, -1, 0);
        expect_sc("R1 new line", 1, 41);

        // R8: store and conditional collide
        for (int p = 0; p < N_OBS; p++) begin
            cyc(1, 20, 0, 0, -1, 0);
            cyc(0, 0, 1, 20, p, 22);
            expect_sc("R8 same line", 0, 20);
            cyc(1, 20, 0, 0, -1, 0);
            cyc(0, 0, 1, 20, p, 24);
            expect_sc("R8 other line", 1, 20);
        end

        // R9: link and conditional together
        cyc(1, 12, 0, 0, -1, 0);
        cyc(1, 50, 1, 13, -1, 0);
        expect_sc("R9 old reservation", 1, 13);
        cyc(0, 0, 1, 50, -1, 0);
        expect_sc("R9 new reservation", 1, 50);
        cyc(0, 0, 1, 50, -1, 0);
        expect_sc("R9 then spent", 0, 50);
        // R9: link together with a store to the same line
        cyc(1, 30, 0, 0, 2, 30);
        cyc(0, 0, 1, 30, -1, 0);
        expect_sc("R9 link beats store", 1, 30);

        // R5: the flag holds across idle cycles
        cyc(0, 0, 1, 4, -1, 0);
        expect_sc("R5 fail", 0, 4);
        cyc(0, 0, 0, 0, 1, 4);
        chk("R5 pulse ends", int'(sc_done), 0);
        chk("R5 no write", int'(mem_we), 0);
        chk("R5 flag held", int'(cc_fail), 1);
        cyc(1, 4, 0, 0, -1, 0);
        chk("R5 flag held after link", int'(cc_fail), 1);
        cyc(0, 0, 1, 5, -1, 0);
        expect_sc("R5 clear on pass", 1, 5);
        cyc(0, 0, 0, 0, -1, 0);
        chk("R5 pass flag held", int'(cc_fail), 0);

        // R7: reset mid-reservation disarms
        cyc(1, 60, 0, 0, -1, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 1, 60, -1, 0);
        expect_sc("R7 reset disarm", 0, 60);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule